// File: doc/BRIEF.md
# Serial Clock Rate Generator

This block turns the core clock into the timing strobes for a serial peripheral bus master. An 8-bit rate field from the configuration register sets the ratio between the core clock and the serial bit period. The block produces two strobes. One is a half-period strobe that the shift logic uses to toggle its serial clock. The other is a full-period tick that marks the end of each bit period. Each strobe is high for exactly one core cycle.

A parameter chooses one of two field encodings at build time. The split encoding gives the ratio as a 4-bit mantissa times a power of two. The exponent is three bits wide, and those bits do not sit next to each other in the field. The legacy encoding holds half of an even ratio in the low four bits.

The field is decoded into a mantissa counter and an exponent counter. The exponent counter runs first and advances the mantissa counter. A field that would stall the block or run it too fast is raised to the slowest safe setting. When a bit that affects the ratio changes, both counters restart.

Top module: `sclk_rate_gen`

## Requirements
- R1: While reset is held, both strobes are low. The count starts at position 0 on the first clock edge after release. If the field is not 0x00 at that edge, the count restarts under the new field, as R6 describes.
- R2: With SPLIT_MODE=1, the ratio R is M × 2^E. M is field[3:0]. E is a 3-bit value whose bit 0 is field bit 4 and whose bits 2:1 are field bits 7:6. Field bit 5 does not affect R.
- R3: With SPLIT_MODE=0, the ratio R is 2 × field[3:0]. Field bits 7:4 do not affect R.
- R4: In split mode an M of 0 counts as 1. In both modes, any ratio below 4 is raised to 4.
- R5: Let the position count run 0..R-1 in core cycles. The full tick is high only at position R-1. The half strobe is high only at positions floor(R/2)-1 and R-1. So the half strobe fires twice per period, and the two strobes coincide at the end of the period.
- R6: A change to any bit that affects R restarts the count at the clock edge where it is seen. The first full tick under the new ratio comes R cycles after that edge.
- R7: A change that touches only bits that do not affect R causes no restart. The strobes keep their timing.
- R8: The largest split ratio, 15 × 128 = 1920 (field 0xDF), gives a 1920-cycle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgField | input | 8 | Rate field from the configuration register |
| halfTick | output | 1 | Half-period strobe for serial clock toggling |
| fullTick | output | 1 | End-of-bit-period strobe |

## Verification
The bench goes after the clamped fields (zero mantissa, ratios 1 to 3) and odd ratios. A design that did not clamp would fire a strobe every core cycle or never fire at all. A design that got the mid-point wrong on an odd ratio would place the half strobe one cycle off. The bench changes the field in the middle of a period, which catches a design that finishes the old period instead of restarting. It also toggles only the ignored bits, which catches a design that restarts on them and so stretches the period. The 1920 ratio exposes an exponent counter that is too narrow, and random fields held for random lengths cover the remaining combinations of mantissa and exponent.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
  localparam int FIELD_W = 8;
  localparam int MANT_W  = 4;
  localparam int EXP_W   = 3;
  localparam int CNT_W   = (1 << EXP_W) - 1;   // exponent counter width
  localparam int MIN_RATIO = 4;

  typedef struct packed {
    logic [MANT_W-1:0] mantTop;   // last mantissa count
    logic [CNT_W-1:0]  expTop;    // last exponent count
    logic [MANT_W-1:0] midMan;    // mantissa count at the mid strobe
    logic [CNT_W-1:0]  midExp;    // exponent count at the mid strobe
  } divCfg_t;

  typedef struct packed {
    logic    restart;
    divCfg_t cfg;
  } ctlStrobe_t;

  // Bits of the field that influence the ratio
  function automatic logic [FIELD_W-1:0] rateKey(input logic [FIELD_W-1:0] f,
                                                 input bit splitMode);
    if (splitMode) rateKey = f & 8'hDF;
    else           rateKey = {4'b0000, f[3:0]};
  endfunction

  function automatic divCfg_t decodeRate(input logic [FIELD_W-1:0] f,
                                         input bit splitMode);
    logic [MANT_W-1:0] mant;
    logic [EXP_W-1:0]  ex;
    logic [CNT_W:0]    span;
    divCfg_t           c;
    mant = f[3:0];
    if (splitMode) begin
      ex = {f[7:6], f[4]};
      if (mant == '0) mant = 4'd1;
    end else begin
      ex = 3'd1;
    end
    // raise ratios below MIN_RATIO
    if (ex == 3'd0 && mant < 4'(MIN_RATIO)) mant = 4'(MIN_RATIO);
    if (ex == 3'd1 && mant < 4'(MIN_RATIO / 2)) mant = 4'(MIN_RATIO / 2);
    span = (CNT_W + 1)'(1) << ex;
    c.mantTop = mant - 4'd1;
    c.expTop  = CNT_W'(span - 1'b1);
    if (ex == 3'd0 || !mant[0]) begin
      c.midMan = (mant >> 1) - 4'd1;
      c.midExp = c.expTop;
    end else begin
      c.midMan = mant >> 1;
      c.midExp = CNT_W'((span >> 1) - 1'b1);
    end
    return c;
  endfunction
endpackage

// File: rtl/sclk_div_ctrl.sv
module sclk_div_ctrl
  import sclk_div_pkg::*;
#(
  parameter bit SPLIT_MODE = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FIELD_W-1:0] cfgField,
  output ctlStrobe_t         ctl
);
  logic [FIELD_W-1:0] keyQ;
  logic [FIELD_W-1:0] keyNow;
  divCfg_t            cfgQ;
  logic               keyMoved;

  assign keyNow   = rateKey(cfgField, SPLIT_MODE);
  assign keyMoved = (keyNow != keyQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyQ <= rateKey('0, SPLIT_MODE);
      cfgQ <= decodeRate('0, SPLIT_MODE);
    end else if (keyMoved) begin
      keyQ <= keyNow;
      cfgQ <= decodeRate(cfgField, SPLIT_MODE);
    end
  end

  assign ctl.restart = keyMoved;
  assign ctl.cfg     = cfgQ;
endmodule

// File: rtl/sclk_div_path.sv
module sclk_div_path
  import sclk_div_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t ctl,
  output logic       halfTick,
  output logic       fullTick
);
  logic [CNT_W-1:0]  expCnt;
  logic [MANT_W-1:0] manCnt;
  logic              preTick;
  logic              periodEnd;
  logic              midHit;

  assign preTick   = (expCnt == ctl.cfg.expTop);
  assign periodEnd = preTick && (manCnt == ctl.cfg.mantTop);
  assign midHit    = (manCnt == ctl.cfg.midMan) && (expCnt == ctl.cfg.midExp);

  // exponent stage: counts core cycles per mantissa step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            expCnt <= '0;
    else if (ctl.restart) expCnt <= '0;
    else if (preTick)     expCnt <= '0;
    else                  expCnt <= expCnt + 1'b1;
  end

  // mantissa stage: advanced by the exponent stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            manCnt <= '0;
    else if (ctl.restart) manCnt <= '0;
    else if (periodEnd)   manCnt <= '0;
    else if (preTick)     manCnt <= manCnt + 1'b1;
  end

  assign fullTick = periodEnd;
  assign halfTick = periodEnd | midHit;
endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen
  import sclk_div_pkg::*;
#(
  parameter bit SPLIT_MODE = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FIELD_W-1:0] cfgField,
  output logic               halfTick,
  output logic               fullTick
);
  ctlStrobe_t ctl;

  sclk_div_ctrl #(.SPLIT_MODE(SPLIT_MODE)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgField (cfgField),
    .ctl      (ctl)
  );

  sclk_div_path uPath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .halfTick (halfTick),
    .fullTick (fullTick)
  );
endmodule

// File: rtl/sclk_div_chk.sv
module sclk_div_chk
  import sclk_div_pkg::*;
#(
  parameter bit SPLIT_MODE = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic [FIELD_W-1:0] cfgField,
  input logic               halfTick,
  input logic               fullTick
);
  // R5: the end of a period is also a half strobe
  a_r5_full_has_half: assert property (@(posedge clk) disable iff (!rstN)
    fullTick |-> halfTick);

  // R5: the full tick lasts a single cycle
  a_r5_full_single: assert property (@(posedge clk) disable iff (!rstN)
    fullTick |=> !fullTick);

  // R4: with a ratio of at least 4, no half strobe directly follows a period end
  a_r4_min_ratio: assert property (@(posedge clk) disable iff (!rstN)
    fullTick |=> !halfTick);

  // R5: the half strobe never fires on two cycles in a row
  a_r5_half_single: assert property (@(posedge clk) disable iff (!rstN)
    halfTick |=> !halfTick);

  // R6: a change to a ratio bit restarts the count, so no tick in the next cycle
  a_r6_restart: assert property (@(posedge clk) disable iff (!rstN)
    (rateKey(cfgField, SPLIT_MODE) != rateKey($past(cfgField), SPLIT_MODE))
      |=> !fullTick);
endmodule

bind sclk_rate_gen sclk_div_chk #(.SPLIT_MODE(SPLIT_MODE)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgField (cfgField),
  .halfTick (halfTick),
  .fullTick (fullTick)
);

// File: tb/sim_sclk_rate_gen.sv
`timescale 1ns/1ps
module sim_sclk_rate_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] fieldS = 8'h00;
  logic [7:0] fieldL = 8'h00;
  logic halfS, fullS, halfL, fullL;
  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  bit started = 0;
  bit done = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  sclk_rate_gen #(.SPLIT_MODE(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .cfgField(fieldS), .halfTick(halfS), .fullTick(fullS));
  sclk_rate_gen #(.SPLIT_MODE(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .cfgField(fieldL), .halfTick(halfL), .fullTick(fullL));

  // R2, R3, R4: expected ratio
  function automatic int ratioOf(input logic [7:0] f, input bit split);
    int m, e, r;
    m = int'(f[3:0]);
    if (split) begin
      if (m == 0) m = 1;
      e = int'({f[7:6], f[4]});
      r = m << e;
    end else begin
      r = 2 * m;
    end
    if (r < 4) r = 4;
    return r;
  endfunction

  // R7: bits that influence the ratio
  function automatic logic [7:0] keyOf(input logic [7:0] f, input bit split);
    return split ? (f & 8'hDF) : {4'h0, f[3:0]};
  endfunction

  int posM [2] = '{0, 0};
  int ratM [2] = '{4, 4};
  logic [7:0] keyM [2] = '{8'h00, 8'h00};

  always @(posedge clk) begin
    started <= 1'b1;
    cyc <= cyc + 1;
    for (int i = 0; i < 2; i++) begin
      logic [7:0] f;
      f = (i == 0) ? fieldS : fieldL;
      if (!rstN) begin
        posM[i] = 0;
        keyM[i] = keyOf(8'h00, i == 0);
        ratM[i] = ratioOf(8'h00, i == 0);
      end else if (keyOf(f, i == 0) != keyM[i]) begin
        posM[i] = 0;
        keyM[i] = keyOf(f, i == 0);
        ratM[i] = ratioOf(f, i == 0);
      end else begin
        posM[i] = (posM[i] + 1) % ratM[i];
      end
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      for (int i = 0; i < 2; i++) begin
        logic eF, eH, aF, aH;
        eF = (posM[i] == ratM[i] - 1);
        eH = eF || (posM[i] == ratM[i] / 2 - 1);
        aF = (i == 0) ? fullS : fullL;
        aH = (i == 0) ? halfS : halfL;
        nChecks++;
        if (aF !== eF || aH !== eH) begin
          nFails++;
          $display("FAIL %s R5 inst%0d ratio %0d pos %0d: full/half actual %b%b expected %b%b",
                   tag, i, ratM[i], posM[i], aF, aH, eF, eH);
        end
      end
    end
  end

  task automatic finishRun();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      nFails++;
      $display("FAIL R5 watchdog expired: actual %0d cycles, expected at most 150000", cyc);
      finishRun();
    end
  end

  task automatic hold(input logic [7:0] fs, input logic [7:0] fl, input int n, input string t);
    tag = t;
    fieldS = fs;
    fieldL = fl;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED1234);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    hold(8'h00, 8'h00, 13, "R1");
    // R2 split decoding, R3 legacy decoding
    hold(8'h05, 8'h13, 23, "R2");
    hold(8'h15, 8'h1F, 65, "R2");
    hold(8'h47, 8'h18, 61, "R3");
    hold(8'hC3, 8'h16, 400, "R2");
    // R4 clamping
    hold(8'h00, 8'h10, 17, "R4");
    hold(8'h10, 8'h11, 17, "R4");
    hold(8'h02, 8'h01, 17, "R4");
    hold(8'h40, 8'h12, 17, "R4");
    hold(8'h03, 8'h00, 17, "R4");
    // R8 largest ratio
    hold(8'hDF, 8'h1F, 3900, "R8");
    // R6 restart in the middle of a period
    hold(8'h0A, 8'h05, 4, "R6");
    hold(8'h0C, 8'h07, 40, "R6");
    hold(8'h1B, 8'h0E, 7, "R6");
    hold(8'h09, 8'h03, 30, "R6");
    // R7 ignored bits: no restart
    hold(8'h0A, 8'h05, 3, "R7");
    hold(8'h2A, 8'hE5, 4, "R7");
    hold(8'h0A, 8'h15, 5, "R7");
    hold(8'h2A, 8'h95, 40, "R7");
    // R5 random fields and hold lengths
    for (int k = 0; k < 120; k++) begin
      logic [7:0] rs, rl;
      rs = 8'($urandom);
      rl = 8'($urandom);
      if (k % 4 == 0) rs[7:6] = 2'b11;
      hold(rs, rl, int'($urandom % 300) + 1, "R5");
    end
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule